// File: doc/BRIEF.md
# Multi-Source Reset Controller with Release Stretching

The controller merges four reset requests into one active-high internal reset. The four requests are a supply power-up detector, an active-low external reset pin, a watchdog expiry strobe and a supply brown-out detector. The analog detectors and the watchdog counter lie outside the block, and each reaches it as a digital input. The power-up, watchdog and brown-out requests raise the internal reset combinationally, with no clock edge needed. The external pin counts only after its low level has survived a synchronizer and a minimum-width filter.

When every request has gone away, a delay counter holds the reset for a further span chosen by a two-bit select, and only then releases it on a clock edge. A request that returns during that span restarts the hold. A four-bit cause register records which requests led to a reset. Software clears a flag by writing 0 to its bit.

Top module: `rst_ctrl_top`

## Requirements
- R1: While `por_i` is high, `rst_o` is high at once, before any clock edge.
- R2: `wdt_expire_i` raises `rst_o` at once only while `wdt_en_i` is high. With the enable low it has no effect on `rst_o` or on the flags.
- R3: `bod_i` raises `rst_o` at once only while `bod_en_i` is high. With the enable low it has no effect on `rst_o` or on the flags.
- R4: A low on `ext_rst_n_i` that spans at least `MIN_LOW` (default 4) consecutive rising edges causes a reset. A shorter low pulse causes none and sets no flag.
- R5: `tsel_i` encodes the hold length D as 0→0, 1→16, 2→64 and 3→256 cycles. `rst_o` falls on the (D+1)-th rising edge after the last request goes inactive, and not before.
- R6: A request that reappears while the hold is running keeps `rst_o` high and restarts the full hold from its new release.
- R7: `flags_o` bit 0 is power-up, bit 1 is external, bit 2 is brown-out and bit 3 is watchdog. A qualified request sets its bit on the next rising edge, and the bit stays set.
- R8: A power-up reset forces `flags_o` to 4'b0001 and clears the other three flags.
- R9: A clock edge with `wr_en_i` high clears each flag whose `wr_data_i` bit is 0 and keeps each flag whose bit is 1. A request that is active in the same cycle takes priority over the clear.
- R10: After a power-up reset `flags_o` reads 4'b0001. With `tsel_i`=0, `rst_o` is low one edge after `por_i` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Always-running controller clock |
| por_i | input | 1 | Supply power-up detector, high while supply is low |
| ext_rst_n_i | input | 1 | External reset pin, active low, asynchronous |
| wdt_expire_i | input | 1 | Watchdog expiry request |
| wdt_en_i | input | 1 | Watchdog reset enable |
| bod_i | input | 1 | Brown-out detector output, high while supply is low |
| bod_en_i | input | 1 | Brown-out reset enable |
| tsel_i | input | 2 | Hold length select |
| wr_en_i | input | 1 | Cause register write strobe |
| wr_data_i | input | 4 | Cause register write data, 0 clears a flag |
| rst_o | output | 1 | Internal reset, active high |
| flags_o | output | 4 | Reset cause flags |

## Verification
The hardest situation to reach from the ports is a request that comes back partway through a running hold, because the restart is visible only as a longer release. The stimulus opens a 16-cycle hold with a brown-out pulse and raises the brown-out request again after eight edges. It then counts a full 16 edges from the second release and expects `rst_o` to be high on the last of them and low one edge later. The pin filter is probed at its boundary: a low pulse of exactly one cycle less than the minimum must leave both the reset and the flags untouched.

// File: rtl/rst_ctrl_pkg.sv
package rst_ctrl_pkg;
  localparam int unsigned NUM_SRC  = 4;
  localparam int unsigned TSEL_W   = 2;
  localparam int unsigned HOLD_W   = 9;

  localparam int unsigned FLG_POR = 0;
  localparam int unsigned FLG_EXT = 1;
  localparam int unsigned FLG_BOD = 2;
  localparam int unsigned FLG_WDT = 3;

  // select 0 -> 0 cycles, n>0 -> 4^(n+1) cycles
  function automatic logic [HOLD_W-1:0] hold_cycles(input logic [TSEL_W-1:0] sel);
    logic [HOLD_W-1:0] r;
    if (sel == '0) r = '0;
    else r = HOLD_W'(1) << (2 * sel + 2);
    return r;
  endfunction
endpackage

// File: rtl/rst_pin_filter.sv
module rst_pin_filter #(
  parameter int unsigned MIN_LOW = 4
) (
  input  logic clk_i,
  input  logic arst_i,
  input  logic pin_n_i,
  output logic qual_o
);
  localparam int unsigned CW = $clog2(MIN_LOW + 1);

  logic             sync1_q, sync2_q;
  logic [CW-1:0]    low_cnt_q;
  logic             pin_low_w;

  always_ff @(posedge clk_i or posedge arst_i) begin
    if (arst_i) begin
      sync1_q <= 1'b1;
      sync2_q <= 1'b1;
    end else begin
      sync1_q <= pin_n_i;
      sync2_q <= sync1_q;
    end
  end

  assign pin_low_w = !sync2_q;

  always_ff @(posedge clk_i or posedge arst_i) begin
    if (arst_i) low_cnt_q <= '0;
    else if (!pin_low_w) low_cnt_q <= '0;
    else if (low_cnt_q != CW'(MIN_LOW)) low_cnt_q <= low_cnt_q + 1'b1;
  end

  assign qual_o = (low_cnt_q == CW'(MIN_LOW));

  // R4: a high synchronized level withdraws the qualification on the next edge
  a_r4_high_drops_qual: assert property (@(posedge clk_i) disable iff (arst_i)
    !pin_low_w |=> !qual_o);
  // R4: qualification only appears after a low sample
  a_r4_rise_needs_low: assert property (@(posedge clk_i) disable iff (arst_i)
    $rose(qual_o) |-> $past(pin_low_w));
endmodule

// File: rtl/rst_stretch.sv
module rst_stretch
  import rst_ctrl_pkg::*;
(
  input  logic              clk_i,
  input  logic              set_i,
  input  logic [HOLD_W-1:0] limit_i,
  output logic              busy_o
);
  logic [HOLD_W-1:0] cnt_q;
  logic              busy_q;
  logic              done_w;

  assign done_w = busy_q && (cnt_q == limit_i);

  always_ff @(posedge clk_i or posedge set_i) begin
    if (set_i) begin
      cnt_q  <= '0;
      busy_q <= 1'b1;
    end else if (busy_q) begin
      if (done_w) busy_q <= 1'b0;
      else cnt_q <= cnt_q + 1'b1;
    end
  end

  assign busy_o = busy_q;

  // R5: release happens only once the count has met the limit
  a_r5_release_at_limit: assert property (@(posedge clk_i) disable iff (set_i)
    $fell(busy_q) |-> $past(cnt_q) == $past(limit_i));
  // R5: an unfinished hold continues
  a_r5_hold_continues: assert property (@(posedge clk_i) disable iff (set_i)
    (busy_q && !done_w) |=> busy_q);
  // R6: a request restarts the count from zero
  a_r6_restart: assert property (@(posedge clk_i)
    set_i |-> (busy_q && cnt_q == '0));
endmodule

// File: rtl/rst_cause_reg.sv
module rst_cause_reg
  import rst_ctrl_pkg::*;
(
  input  logic               clk_i,
  input  logic               por_i,
  input  logic               ext_i,
  input  logic               bod_i,
  input  logic               wdt_i,
  input  logic               wr_en_i,
  input  logic [NUM_SRC-1:0] wr_data_i,
  output logic [NUM_SRC-1:0] flags_o
);
  logic [NUM_SRC-1:0] flags_q;
  logic [NUM_SRC-1:0] hit_w;
  logic [NUM_SRC-1:0] keep_w;

  always_comb begin
    hit_w          = '0;
    hit_w[FLG_EXT] = ext_i;
    hit_w[FLG_BOD] = bod_i;
    hit_w[FLG_WDT] = wdt_i;
    keep_w         = wr_en_i ? wr_data_i : '1;
  end

  always_ff @(posedge clk_i or posedge por_i) begin
    if (por_i) flags_q <= NUM_SRC'(1) << FLG_POR;
    else flags_q <= (flags_q & keep_w) | hit_w;
  end

  assign flags_o = flags_q;

  // R7: a qualified watchdog request is recorded
  a_r7_wdt_recorded: assert property (@(posedge clk_i) disable iff (por_i)
    wdt_i |=> flags_o[FLG_WDT]);
  // R7: a qualified brown-out request is recorded
  a_r7_bod_recorded: assert property (@(posedge clk_i) disable iff (por_i)
    bod_i |=> flags_o[FLG_BOD]);
  // R9: a write of 0 without a request clears the bit
  a_r9_clear_ext: assert property (@(posedge clk_i) disable iff (por_i)
    (wr_en_i && !wr_data_i[FLG_EXT] && !ext_i) |=> !flags_o[FLG_EXT]);
  // R9: without a write a set flag stays set
  a_r9_sticky_por: assert property (@(posedge clk_i) disable iff (por_i)
    (!wr_en_i && flags_o[FLG_POR]) |=> flags_o[FLG_POR]);
endmodule

// File: rtl/rst_ctrl_top.sv
module rst_ctrl_top
  import rst_ctrl_pkg::*;
#(
  parameter int unsigned MIN_LOW = 4
) (
  input  logic               clk_i,
  input  logic               por_i,
  input  logic               ext_rst_n_i,
  input  logic               wdt_expire_i,
  input  logic               wdt_en_i,
  input  logic               bod_i,
  input  logic               bod_en_i,
  input  logic [TSEL_W-1:0]  tsel_i,
  input  logic               wr_en_i,
  input  logic [NUM_SRC-1:0] wr_data_i,
  output logic               rst_o,
  output logic [NUM_SRC-1:0] flags_o
);
  logic wdt_req_w, bod_req_w, ext_req_w;
  logic async_req_w, any_req_w, busy_w;
  logic [HOLD_W-1:0] limit_w;

  assign wdt_req_w   = wdt_expire_i && wdt_en_i;
  assign bod_req_w   = bod_i && bod_en_i;
  assign async_req_w = por_i || wdt_req_w || bod_req_w;
  assign any_req_w   = async_req_w || ext_req_w;
  assign limit_w     = hold_cycles(tsel_i);

  rst_pin_filter #(.MIN_LOW(MIN_LOW)) u_filter (
    .clk_i   (clk_i),
    .arst_i  (por_i),
    .pin_n_i (ext_rst_n_i),
    .qual_o  (ext_req_w)
  );

  rst_stretch u_stretch (
    .clk_i   (clk_i),
    .set_i   (any_req_w),
    .limit_i (limit_w),
    .busy_o  (busy_w)
  );

  rst_cause_reg u_cause (
    .clk_i     (clk_i),
    .por_i     (por_i),
    .ext_i     (ext_req_w),
    .bod_i     (bod_req_w),
    .wdt_i     (wdt_req_w),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .flags_o   (flags_o)
  );

  assign rst_o = any_req_w || busy_w;

  // R1: power-up request drives the reset without a clock
  always_comb begin
    if (por_i) a_r1_por_immediate: assert (rst_o);
  end
  // R2: enabled watchdog request holds the reset
  a_r2_wdt_reset: assert property (@(posedge clk_i) disable iff (por_i)
    (wdt_expire_i && wdt_en_i) |-> rst_o);
  // R3: enabled brown-out request holds the reset
  a_r3_bod_reset: assert property (@(posedge clk_i) disable iff (por_i)
    (bod_i && bod_en_i) |-> rst_o);
  // R5: release only when no request is present
  a_r5_release_clean: assert property (@(posedge clk_i) disable iff (por_i)
    $fell(rst_o) |-> !any_req_w);
endmodule

// File: tb/rst_ctrl_top_test.sv
module rst_ctrl_top_test;
  localparam time CLK_PERIOD = 10;
  localparam int MIN_LOW = 4;

  logic clk = 1'b0;
  logic por, ext_n, wdt, wdt_en, bod, bod_en, wr_en;
  logic [1:0] tsel;
  logic [3:0] wr_data, flags;
  logic rst;
  int errors = 0, checks = 0;

  rst_ctrl_top #(.MIN_LOW(MIN_LOW)) uut (
    .clk_i(clk), .por_i(por), .ext_rst_n_i(ext_n), .wdt_expire_i(wdt),
    .wdt_en_i(wdt_en), .bod_i(bod), .bod_en_i(bod_en), .tsel_i(tsel),
    .wr_en_i(wr_en), .wr_data_i(wr_data), .rst_o(rst), .flags_o(flags)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  function automatic int hold_len(input int sel);
    case (sel)
      0: return 0;
      1: return 16;
      2: return 64;
      default: return 256;
    endcase
  endfunction

  task automatic t_power_up();
    #2;
    check(rst, 1, "R1 reset before first edge");
    edges(2);
    check(flags, 4'b0001, "R10 flags after power-up");
    @(negedge clk); por = 1'b0;
    edges(1);
    check(rst, 0, "R10 release one edge after power-up with tsel 0");
  endtask

  task automatic t_hold(input int sel);
    int d = hold_len(sel);
    @(negedge clk); tsel = 2'(sel); bod_en = 1'b1; bod = 1'b1;
    #1 check(rst, 1, "R3 brown-out raises reset at once");
    edges(1);
    @(negedge clk); bod = 1'b0;
    if (d > 0) begin
      edges(d);
      check(rst, 1, $sformatf("R5 still held after %0d edges", d));
    end
    edges(1);
    check(rst, 0, $sformatf("R5 released on edge %0d", d + 1));
    check(flags[2], 1, "R7 brown-out flag bit 2");
  endtask

  task automatic t_restart();
    @(negedge clk); tsel = 2'd1; bod = 1'b1;
    edges(1);
    @(negedge clk); bod = 1'b0;
    edges(8);
    @(negedge clk); bod = 1'b1;
    #1 check(rst, 1, "R6 reset high on re-request");
    edges(1);
    @(negedge clk); bod = 1'b0;
    edges(16);
    check(rst, 1, "R6 full hold restarted");
    edges(1);
    check(rst, 0, "R6 release after restarted hold");
  endtask

  task automatic t_gating();
    @(negedge clk); tsel = 2'd0; wr_en = 1'b1; wr_data = 4'b0000;
    @(negedge clk); wr_en = 1'b0; wr_data = 4'b1111;
    check(flags, 4'b0000, "R9 write of zeros clears all flags");
    wdt_en = 1'b0; wdt = 1'b1; bod_en = 1'b0; bod = 1'b1;
    edges(3);
    check(rst, 0, "R2 disabled watchdog no reset");
    check(flags, 4'b0000, "R2 R3 disabled sources set no flag");
    @(negedge clk); bod = 1'b0; wdt_en = 1'b1;
    #1 check(rst, 1, "R2 enabled watchdog raises reset at once");
    @(negedge clk); wr_en = 1'b1; wr_data = 4'b0111;
    edges(1);
    check(flags[3], 1, "R9 active request wins over clear");
    @(negedge clk); wr_en = 1'b0; wr_data = 4'b1111; wdt = 1'b0; wdt_en = 1'b0;
    edges(2);
    check(rst, 0, "R2 release after watchdog");
    check(flags, 4'b1000, "R7 watchdog flag bit 3");
  endtask

  task automatic pulse_pin(input int n, output logic saw);
    saw = 1'b0;
    @(negedge clk); ext_n = 1'b0;
    for (int i = 0; i < n + 6; i++) begin
      @(negedge clk);
      if (i == n - 1) ext_n = 1'b1;
      if (rst) saw = 1'b1;
    end
  endtask

  task automatic t_pin();
    logic saw;
    pulse_pin(MIN_LOW - 1, saw);
    check(saw, 0, "R4 short low pulse ignored");
    check(flags[1], 0, "R4 short pulse sets no flag");
    pulse_pin(MIN_LOW, saw);
    check(saw, 1, "R4 minimum-width low pulse resets");
    edges(2);
    check(flags, 4'b1010, "R7 external flag bit 1");
    check(rst, 0, "R4 reset released after pin pulse");
  endtask

  task automatic t_clear_and_por();
    @(negedge clk); wr_en = 1'b1; wr_data = 4'b0101;
    @(negedge clk); wr_en = 1'b0; wr_data = 4'b1111;
    check(flags, 4'b0000, "R9 zero bits cleared, one bits kept");
    wdt_en = 1'b1; wdt = 1'b1;
    edges(1);
    @(negedge clk); wdt = 1'b0; wdt_en = 1'b0;
    check(flags, 4'b1000, "R7 watchdog flag before power-up");
    por = 1'b1;
    #1 check(flags, 4'b0001, "R8 power-up clears other flags");
    check(rst, 1, "R1 power-up raises reset");
    @(negedge clk); por = 1'b0;
    edges(2);
    check(rst, 0, "R10 release after second power-up");
  endtask

  initial begin
    por = 1'b1; ext_n = 1'b1; wdt = 1'b0; wdt_en = 1'b0; bod = 1'b0; bod_en = 1'b0;
    tsel = 2'd0; wr_en = 1'b0; wr_data = 4'b1111;
    t_power_up();
    for (int s = 0; s < 4; s++) t_hold(s);
    t_restart();
    t_gating();
    t_pin();
    t_clear_and_por();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule